// File: doc/BRIEF.md
# Micro-TLB with Lazy Invalidation

This block is a small, fully associative translation cache placed in front of a larger set-associative main TLB. A lookup carries a virtual page number and an address-space identifier (ASID). On a hit the block returns the physical frame number and the permission bits one cycle later. On a miss it reports the miss, requests the translation from the main TLB, and writes the returned entry into a victim slot. The default build has 8 ways for the data side. The instruction side uses the same module with `WAYS = 4`.

Entries here do not track the main TLB's contents. When the main TLB replaces one of its own entries with a write that does not invalidate, copies held here stay valid. Because of this, pages that fight over one set of the main TLB can all stay resident here at once. The only thing that clears this cache is a single invalidate-all pulse. The main TLB raises that pulse on a normal write or on an explicit invalidate command.

The lookup port and the miss-request port use valid/ready handshakes. A lookup is accepted only while `lkp_ready` is high. `lkp_ready` goes low from an accepted miss until the fill lands or an invalidate abandons the miss. The miss request holds its valid and its payload until `mreq_ready` is seen. The result and fill ports are valid-only, with no back-pressure: the requester must take `res_*` in the cycle `res_valid` is high, and the main TLB presents a fill for exactly one cycle.

Top module: `utlb_cache`

## Requirements
- R1: A lookup is accepted in a cycle where `lkp_valid` and `lkp_ready` are both high. `res_valid` is high in the following cycle, for one cycle only, and is low in every other cycle.
- R2: A lookup hits when a valid entry has an equal page number and either an equal ASID or its global flag set. The result then carries that entry's frame number and permission bits.
- R3: A lookup that misses (with no invalidate in the same cycle) gives `res_hit` = 0. In the same cycle, `mreq_valid` rises with the missed page number and ASID. The request and its payload are held until `mreq_ready`, and `lkp_ready` stays low meanwhile.
- R4: After the request handshake, the next `fill_valid` writes an entry built from the missed page/ASID, `fill_pfn`, `fill_perm` and `fill_global`, and `lkp_ready` returns high in the next cycle. A `fill_valid` at any other time is ignored.
- R5: The victim is the lowest-numbered empty slot. When every slot is full, a round-robin pointer picks the victim. The pointer starts at slot 0 after reset and advances by one, wrapping, after each replacement of a full cache.
- R6: Installed entries stay valid, whatever the main TLB does, until an invalidate pulse. Up to `WAYS` pages that collide in one main-TLB set all remain resident together.
- R7: An `inv_all` pulse empties every slot and returns the block to ready in the next cycle, dropping any outstanding miss request.
- R8: When `inv_all` and `fill_valid` arrive in the same cycle, the fill is discarded.
- R9: A lookup accepted in the same cycle as `inv_all` reports `res_hit` = 0 and raises no miss request.
- R10: After reset, all slots are empty, `lkp_ready` = 1, `res_valid` = 0 and `mreq_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request valid |
| lkp_ready | output | 1 | Block can accept a lookup |
| lkp_vpn | input | VPN_W | Virtual page number to translate |
| lkp_asid | input | ASID_W | Address-space identifier of the lookup |
| res_valid | output | 1 | Lookup result valid (one cycle) |
| res_hit | output | 1 | Lookup hit |
| res_pfn | output | PFN_W | Frame number on a hit |
| res_perm | output | PERM_W | Permission bits on a hit |
| mreq_valid | output | 1 | Miss request to the main TLB |
| mreq_ready | input | 1 | Main TLB accepts the miss request |
| mreq_vpn | output | VPN_W | Page number of the missed lookup |
| mreq_asid | output | ASID_W | ASID of the missed lookup |
| fill_valid | input | 1 | Fill response from the main TLB |
| fill_pfn | input | PFN_W | Frame number of the fill |
| fill_perm | input | PERM_W | Permission bits of the fill |
| fill_global | input | 1 | Fill entry matches every ASID |
| inv_all | input | 1 | Invalidate every entry |

## Verification
Two pairs of events can land in the same cycle, and both are provoked on purpose. In the first, the bench drives the invalidate pulse in the exact cycle that the fill response is presented. It then looks up the missed page and a page that was resident before; both must miss, which shows the fill was dropped and the invalidate won. In the second, the bench asserts the invalidate together with an accepted lookup of a resident page. It expects a miss with no miss request and the port ready again at once, and a later lookup of the same page must also miss.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  parameter int VPN_W  = 19;
  parameter int ASID_W = 8;
  parameter int PFN_W  = 19;
  parameter int PERM_W = 6;

  typedef struct packed {
    logic              vld;
    logic              glb;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PFN_W-1:0]  pfn;
    logic [PERM_W-1:0] perm;
  } utlb_entry_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } utlb_state_e;
endpackage

// File: rtl/utlb_match.sv
module utlb_match import utlb_pkg::*; #(
  parameter int WAYS = 8
) (
  input  utlb_entry_t [WAYS-1:0] ents,
  input  logic [VPN_W-1:0]       vpn,
  input  logic [ASID_W-1:0]      asid,
  output logic                   hit,
  output logic [PFN_W-1:0]       pfn,
  output logic [PERM_W-1:0]      perm
);
  logic [WAYS-1:0] hit_vec;

  // Per-way compare: page equal and (ASID equal or global entry)
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = ents[g].vld && (ents[g].vpn == vpn) &&
                        (ents[g].glb || (ents[g].asid == asid));
  end

  // Lowest matching way wins
  always_comb begin
    hit  = |hit_vec;
    pfn  = '0;
    perm = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        pfn  = ents[i].pfn;
        perm = ents[i].perm;
      end
    end
  end
endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
  parameter int WAYS  = 8,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  vld_vec,
  input  logic             install,
  output logic [IDX_W-1:0] vict_idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             all_full;

  assign all_full = &vld_vec;

  always_comb begin
    free_idx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!vld_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign vict_idx = all_full ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (install && all_full) begin
      if (rr_q == IDX_W'(WAYS - 1)) rr_q <= '0;
      else                          rr_q <= rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/utlb_ctrl.sv
module utlb_ctrl import utlb_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lkp_fire,
  input  logic        lkp_hit,
  input  logic        mreq_ready,
  input  logic        fill_valid,
  input  logic        inv_all,
  output utlb_state_e state,
  output logic        install
);
  utlb_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (lkp_fire && !lkp_hit) nxt = ST_REQ;
      ST_REQ:  if (mreq_ready)           nxt = ST_WAIT;
      ST_WAIT: if (fill_valid)           nxt = ST_IDLE;
      default:                           nxt = ST_IDLE;
    endcase
    if (inv_all) nxt = ST_IDLE;
  end

  assign install = (state == ST_WAIT) && fill_valid && !inv_all;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/utlb_cache.sv
module utlb_cache import utlb_pkg::*; #(
  parameter int WAYS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  output logic              lkp_ready,
  input  logic [VPN_W-1:0]  lkp_vpn,
  input  logic [ASID_W-1:0] lkp_asid,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PFN_W-1:0]  res_pfn,
  output logic [PERM_W-1:0] res_perm,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [VPN_W-1:0]  mreq_vpn,
  output logic [ASID_W-1:0] mreq_asid,
  input  logic              fill_valid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              fill_global,
  input  logic              inv_all
);
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  utlb_entry_t [WAYS-1:0] ent_q;
  logic [WAYS-1:0]        vld_vec;
  logic [VPN_W-1:0]       cap_vpn_q;
  logic [ASID_W-1:0]      cap_asid_q;
  logic                   m_hit;
  logic [PFN_W-1:0]       m_pfn;
  logic [PERM_W-1:0]      m_perm;
  logic [IDX_W-1:0]       vict_idx;
  logic                   install;
  logic                   lkp_fire;
  utlb_state_e            state;

  for (genvar g = 0; g < WAYS; g++) begin : g_vld
    assign vld_vec[g] = ent_q[g].vld;
  end

  assign lkp_ready  = (state == ST_IDLE);
  assign lkp_fire   = lkp_valid && lkp_ready;
  assign mreq_valid = (state == ST_REQ);
  assign mreq_vpn   = cap_vpn_q;
  assign mreq_asid  = cap_asid_q;

  utlb_match #(.WAYS(WAYS)) u_match (
    .ents (ent_q),
    .vpn  (lkp_vpn),
    .asid (lkp_asid),
    .hit  (m_hit),
    .pfn  (m_pfn),
    .perm (m_perm)
  );

  utlb_victim #(.WAYS(WAYS)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_vec  (vld_vec),
    .install  (install),
    .vict_idx (vict_idx)
  );

  utlb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lkp_fire   (lkp_fire),
    .lkp_hit    (m_hit && !inv_all),
    .mreq_ready (mreq_ready),
    .fill_valid (fill_valid),
    .inv_all    (inv_all),
    .state      (state),
    .install    (install)
  );

  // Entry storage: invalidate beats install
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (inv_all) begin
      for (int i = 0; i < WAYS; i++) ent_q[i].vld <= 1'b0;
    end else if (install) begin
      ent_q[vict_idx] <= '{vld: 1'b1, glb: fill_global, vpn: cap_vpn_q,
                           asid: cap_asid_q, pfn: fill_pfn, perm: fill_perm};
    end
  end

  // Captured lookup key, used for the miss request and the install
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_vpn_q  <= '0;
      cap_asid_q <= '0;
    end else if (lkp_fire) begin
      cap_vpn_q  <= lkp_vpn;
      cap_asid_q <= lkp_asid;
    end
  end

  // Registered result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_pfn   <= '0;
      res_perm  <= '0;
    end else begin
      res_valid <= lkp_fire;
      if (lkp_fire) begin
        res_hit  <= m_hit && !inv_all;
        res_pfn  <= m_pfn;
        res_perm <= m_perm;
      end
    end
  end
endmodule

// File: rtl/utlb_cache_chk.sv
module utlb_cache_chk import utlb_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              lkp_valid,
  input logic              lkp_ready,
  input logic              res_valid,
  input logic              res_hit,
  input logic              mreq_valid,
  input logic              mreq_ready,
  input logic [VPN_W-1:0]  mreq_vpn,
  input logic [ASID_W-1:0] mreq_asid,
  input logic              inv_all
);
  a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lkp_ready) |=> res_valid);

  a_r1_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
    !(lkp_valid && lkp_ready) |=> !res_valid);

  a_r3_miss_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit && !$past(inv_all)) |-> mreq_valid);

  a_r3_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready && !inv_all) |=>
      (mreq_valid && $stable(mreq_vpn) && $stable(mreq_asid)));

  a_r7_inv_ready: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (lkp_ready && !mreq_valid));

  a_r9_inv_lookup_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && lkp_valid && lkp_ready) |=> !res_hit);
endmodule

bind utlb_cache utlb_cache_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lkp_valid  (lkp_valid),
  .lkp_ready  (lkp_ready),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .mreq_valid (mreq_valid),
  .mreq_ready (mreq_ready),
  .mreq_vpn   (mreq_vpn),
  .mreq_asid  (mreq_asid),
  .inv_all    (inv_all)
);

// File: tb/utlb_cache_tb.sv
`timescale 1ns/1ps
module utlb_cache_tb;
  import utlb_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lkp_valid = 1'b0;
  logic              lkp_ready;
  logic [VPN_W-1:0]  lkp_vpn = '0;
  logic [ASID_W-1:0] lkp_asid = '0;
  logic              res_valid, res_hit;
  logic [PFN_W-1:0]  res_pfn;
  logic [PERM_W-1:0] res_perm;
  logic              mreq_valid;
  logic              mreq_ready = 1'b0;
  logic [VPN_W-1:0]  mreq_vpn;
  logic [ASID_W-1:0] mreq_asid;
  logic              fill_valid = 1'b0;
  logic [PFN_W-1:0]  fill_pfn = '0;
  logic [PERM_W-1:0] fill_perm = '0;
  logic              fill_global = 1'b0;
  logic              inv_all = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  utlb_cache #(.WAYS(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_vpn(lkp_vpn), .lkp_asid(lkp_asid),
    .res_valid(res_valid), .res_hit(res_hit), .res_pfn(res_pfn), .res_perm(res_perm),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_vpn(mreq_vpn), .mreq_asid(mreq_asid),
    .fill_valid(fill_valid), .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_global(fill_global),
    .inv_all(inv_all)
  );

  function automatic logic [PERM_W-1:0] perm_of(input logic [PFN_W-1:0] p);
    return p[PERM_W-1:0] ^ 6'h15;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Issue one lookup; optionally with an invalidate in the same cycle
  task automatic do_lookup(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input bit inv_same);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_vpn = v; lkp_asid = a; inv_all = inv_same;
    @(posedge clk);
    @(negedge clk);
    lkp_valid = 1'b0; inv_all = 1'b0;
    chk(res_valid === 1'b1, "R1 res_valid after accept", 32'(res_valid), 32'd1);
  endtask

  // Serve a pending miss as the main TLB would
  task automatic serve(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                       input logic [PFN_W-1:0] p, input bit g, input bit inv_with_fill);
    chk(mreq_valid === 1'b1, "R3 miss request raised", 32'(mreq_valid), 32'd1);
    chk(mreq_vpn === v, "R3 miss request vpn", 32'(mreq_vpn), 32'(v));
    chk(mreq_asid === a, "R3 miss request asid", 32'(mreq_asid), 32'(a));
    chk(lkp_ready === 1'b0, "R3 busy during miss", 32'(lkp_ready), 32'd0);
    mreq_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mreq_ready = 1'b0;
    fill_valid = 1'b1; fill_pfn = p; fill_perm = perm_of(p); fill_global = g;
    inv_all = inv_with_fill;
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0; inv_all = 1'b0;
    chk(lkp_ready === 1'b1, "R4 ready after fill", 32'(lkp_ready), 32'd1);
  endtask

  // Lookup; check hit expectation; on hit check data, on miss fill with p
  task automatic probe(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                       input bit exp_hit, input logic [PFN_W-1:0] p, input bit g, input string req);
    do_lookup(v, a, 1'b0);
    chk(res_hit === exp_hit, req, 32'(res_hit), 32'(exp_hit));
    if (exp_hit && res_hit) begin
      chk(res_pfn === p, req, 32'(res_pfn), 32'(p));
      chk(res_perm === perm_of(p), req, 32'(res_perm), 32'(perm_of(p)));
    end
    if (!res_hit) serve(v, a, p, g, 1'b0);
  endtask

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              glb;
    logic              hit;
    logic [PFN_W-1:0]  pfn;
  } vec_t;

  // Pages 0x100/0x200/0x300 share low index bits, so they collide in a 2-way main TLB
  localparam vec_t VECS [11] = '{
    '{19'h100, 8'd1, 1'b0, 1'b0, 19'h500},
    '{19'h200, 8'd1, 1'b0, 1'b0, 19'h600},
    '{19'h300, 8'd1, 1'b0, 1'b0, 19'h700},
    '{19'h100, 8'd1, 1'b0, 1'b1, 19'h500},
    '{19'h200, 8'd1, 1'b0, 1'b1, 19'h600},
    '{19'h300, 8'd1, 1'b0, 1'b1, 19'h700},
    '{19'h100, 8'd2, 1'b0, 1'b0, 19'h510},
    '{19'h100, 8'd2, 1'b0, 1'b1, 19'h510},
    '{19'h100, 8'd1, 1'b0, 1'b1, 19'h500},
    '{19'h040, 8'd3, 1'b1, 1'b0, 19'h800},
    '{19'h040, 8'd7, 1'b1, 1'b1, 19'h800}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk(lkp_ready === 1'b1, "R10 ready after reset", 32'(lkp_ready), 32'd1);
    chk(res_valid === 1'b0, "R10 no result after reset", 32'(res_valid), 32'd0);
    chk(mreq_valid === 1'b0, "R10 no request after reset", 32'(mreq_valid), 32'd0);

    // Table: R2 match rules, R6 colliding pages resident together
    for (int k = 0; k < 11; k++) begin
      probe(VECS[k].vpn, VECS[k].asid, VECS[k].hit, VECS[k].pfn, VECS[k].glb, "R2/R6 table");
    end

    // R1: result pulse lasts one cycle
    @(negedge clk);
    chk(res_valid === 1'b0, "R1 result single cycle", 32'(res_valid), 32'd0);

    // R3: request held while mreq_ready low
    do_lookup(19'h901, 8'd1, 1'b0);
    chk(res_hit === 1'b0, "R3 miss reported", 32'(res_hit), 32'd0);
    @(negedge clk);
    chk(mreq_valid === 1'b1 && mreq_vpn === 19'h901, "R3 request held", 32'(mreq_vpn), 32'h901);
    serve(19'h901, 8'd1, 19'h901, 1'b0, 1'b0);   // slot 5
    probe(19'h902, 8'd1, 1'b0, 19'h902, 1'b0, "R5 fill slot 6");
    probe(19'h903, 8'd1, 1'b0, 19'h903, 1'b0, "R5 fill slot 7");
    // R5: full -> round robin from slot 0
    probe(19'h904, 8'd1, 1'b0, 19'h904, 1'b0, "R5 replace slot 0");
    probe(19'h200, 8'd1, 1'b1, 19'h600, 1'b0, "R5 slot 1 kept");
    probe(19'h100, 8'd1, 1'b0, 19'h501, 1'b0, "R5 slot 0 evicted");      // into slot 1
    probe(19'h200, 8'd1, 1'b0, 19'h601, 1'b0, "R5 slot 1 evicted");      // into slot 2
    probe(19'h100, 8'd2, 1'b1, 19'h510, 1'b0, "R5 slot 3 kept");
    probe(19'h300, 8'd1, 1'b0, 19'h701, 1'b0, "R5 slot 2 evicted");      // into slot 3
    probe(19'h100, 8'd2, 1'b0, 19'h511, 1'b0, "R5 slot 3 evicted");
    probe(19'h904, 8'd1, 1'b1, 19'h904, 1'b0, "R6 still resident");

    // R7: invalidate empties the cache
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    probe(19'h904, 8'd1, 1'b0, 19'h111, 1'b0, "R7 cleared by invalidate");

    // R4: stray fill while idle is ignored
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    fill_valid = 1'b1; fill_pfn = 19'h0BAD; fill_perm = '0; fill_global = 1'b1;
    @(negedge clk); fill_valid = 1'b0;
    probe(19'h904, 8'd1, 1'b0, 19'h222, 1'b0, "R4 stray fill ignored");

    // R9: invalidate with accepted lookup of a resident page
    do_lookup(19'h904, 8'd1, 1'b1);
    chk(res_hit === 1'b0, "R9 lookup with invalidate misses", 32'(res_hit), 32'd0);
    chk(mreq_valid === 1'b0, "R9 no request", 32'(mreq_valid), 32'd0);
    chk(lkp_ready === 1'b1, "R9 ready", 32'(lkp_ready), 32'd1);
    probe(19'h904, 8'd1, 1'b0, 19'h333, 1'b0, "R9 entry gone");

    // R8: invalidate in the fill cycle drops the fill
    do_lookup(19'h950, 8'd4, 1'b0);
    chk(res_hit === 1'b0, "R8 setup miss", 32'(res_hit), 32'd0);
    serve(19'h950, 8'd4, 19'h444, 1'b0, 1'b1);
    probe(19'h950, 8'd4, 1'b0, 19'h445, 1'b0, "R8 fill dropped");
    probe(19'h904, 8'd1, 1'b0, 19'h334, 1'b0, "R8 invalidate won");

    // R7: invalidate abandons outstanding request
    do_lookup(19'hA00, 8'd5, 1'b0);
    chk(mreq_valid === 1'b1, "R7 request pending", 32'(mreq_valid), 32'd1);
    inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    chk(mreq_valid === 1'b0, "R7 request dropped", 32'(mreq_valid), 32'd0);
    chk(lkp_ready === 1'b1, "R7 ready again", 32'(lkp_ready), 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule